// File: doc/BRIEF.md
# CCD Frame Mode Sequencer

This block lays out the vertical frame of a frame-transfer CCD. It counts lines against an end-of-line strobe that a line timing block qualifies with the pixel clock enable. It decodes that count into the vertical events of one frame: the charge-reset window, the window in which the storage section is shifted line by line into the output register, and the window in which those lines carry active picture. The per-line phase waveforms come from another sequencer. That sequencer takes the enables from this block.

The block has two modes. In still mode the whole picture is read out at full resolution, and the frame lasts 2035 lines. In monitor mode the frame lasts 315 lines. Early in each monitor frame, a fast image-to-storage transfer runs at one vertical step every 16 pixel enables. During this transfer a keep strobe marks which steps land in storage: every edge line, and then 2 out of each 10 picture lines. A mode request that arrives mid-frame is held until the counter wraps. Once a start request takes the sequencer out of idle, it runs frames without a break.

Top module: `ccd_frame_seq`

## Requirements
- R1: After reset and until a start request, lineCount is 0 and frameValid, chargeReset, frameShiftEn, xferStrobe, keepStrobe, lineShiftEn and lineValid are all low.
- R2: When startReq is high while idle, frameValid is high from the next cycle, lineCount is 0 and the mode is taken from modeMonitor (1 = monitor, 0 = still). A startReq while running is ignored.
- R3: While running, lineCount advances by one in each cycle in which pixEn and lineEnd are both high, and holds otherwise.
- R4: lineCount wraps to 0 after line STILL_LINES-1 (2034) in still mode and after line MON_LINES-1 (314) in monitor mode.
- R5: modeMonitor is sampled only on the advance that wraps lineCount to 0. A change during a frame does not alter that frame.
- R6: chargeReset is high for the whole of line STILL_CR (1628) in still mode and line MON_CR (113) in monitor mode.
- R7: In still mode, lineShiftEn is high on lines STILL_LS_FIRST..STILL_LS_LAST (2..1626). lineValid is high on the ACTIVE_LINES (1296) lines that start at STILL_LS_FIRST+STORE_LINES+EDGE_LINES (316).
- R8: In monitor mode, frameShiftEn rises on the advance into line MON_FS_LINE (1). Transfers are numbered from 0, and transfer k ends on the FS_DIV-th (16th) pixEn of its slot. xferStrobe pulses in that cycle. After EDGE_LINES+ACTIVE_LINES+TOP_LINES (1324) transfers, frameShiftEn falls. In still mode, frameShiftEn never rises.
- R9: keepStrobe pulses only together with xferStrobe. It pulses for transfers k < EDGE_LINES (16). For the SUB_SPAN (1290) transfers that follow, it pulses when (k-EDGE_LINES) mod GROUP < KEEP (2 of 10), which gives 258 kept picture lines. It never pulses for later transfers.
- R10: In monitor mode, lineShiftEn is high on lines MON_LS_FIRST..MON_LS_LAST (18..314). lineValid is high on the SUB_SPAN/GROUP*KEEP (258) lines that start at MON_LS_FIRST+EDGE_LINES (34).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel clock enable |
| lineEnd | input | 1 | End-of-line strobe from line timing |
| modeMonitor | input | 1 | Requested mode: 1 monitor, 0 still |
| startReq | input | 1 | Leave idle and begin frames |
| lineCount | output | LCW (11) | Line index within the frame |
| chargeReset | output | 1 | Charge-reset window |
| frameShiftEn | output | 1 | Fast image-to-storage transfer active |
| xferStrobe | output | 1 | One vertical step of the fast transfer completes |
| keepStrobe | output | 1 | The step now completing is kept in storage |
| lineShiftEn | output | 1 | Storage-to-register line shift enabled this line |
| frameValid | output | 1 | Sequencer running |
| lineValid | output | 1 | Current line carries active picture |

## Verification
The sequencer is driven in three ways, with a compact geometry set by parameters. The first uses a steady enable and a regular line strobe. The second uses a pixel enable with gaps, so that some line strobes fall on disabled cycles and must be ignored, and the transfer cadence has to count enables rather than cycles. The third changes the mode request mid-frame and sends start requests while running, which separates mode latching at the wrap from latching at once. Per-frame checks on frame length, transfer count and kept-step count show whether a wrong wrap point, divider or subsampling phase is at fault.

// File: rtl/ccd_frame_seq_pkg.sv
package ccd_frame_seq_pkg;

  typedef enum logic {
    MODE_STILL   = 1'b0,
    MODE_MONITOR = 1'b1
  } frameMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic running;    // sequencer out of idle
    logic lineAdv;    // qualified line advance this cycle
    logic frameWrap;  // advance lands on line 0
    logic fsStart;    // begin fast frame transfer
  } seqStrobe_t;

endpackage

// File: rtl/ccd_frame_seq_ctrl.sv
module ccd_frame_seq_ctrl
  import ccd_frame_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixEn,
  input  logic       lineEnd,
  input  logic       startReq,
  input  logic       modeMonitor,
  input  logic       atLast,
  input  logic       atFsPrev,
  output seqStrobe_t strb,
  output frameMode_t activeMode
);

  logic running;
  logic lineAdv;

  assign lineAdv = running && pixEn && lineEnd;

  always_comb begin
    strb.running   = running;
    strb.lineAdv   = lineAdv;
    strb.frameWrap = lineAdv && atLast;
    strb.fsStart   = lineAdv && (activeMode == MODE_MONITOR) && atFsPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      activeMode <= MODE_STILL;
    end else if (!running) begin
      if (startReq) begin
        running    <= 1'b1;
        activeMode <= frameMode_t'(modeMonitor);
      end
    end else if (strb.frameWrap) begin
      activeMode <= frameMode_t'(modeMonitor);
    end
  end

  AST_START_TAKES_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq) |=> (running && ((activeMode == MODE_MONITOR) == $past(modeMonitor)))); // R2

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running); // R2

  AST_MODE_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(pixEn && lineEnd && atLast)) |=> $stable(activeMode)); // R5

endmodule

// File: rtl/ccd_frame_seq_dpath.sv
module ccd_frame_seq_dpath
  import ccd_frame_seq_pkg::*;
#(
  parameter int LCW            = 11,
  parameter int STILL_LINES    = 2035,
  parameter int MON_LINES      = 315,
  parameter int STILL_CR       = 1628,
  parameter int MON_CR         = 113,
  parameter int STILL_LS_FIRST = 2,
  parameter int STILL_LS_LAST  = 1626,
  parameter int MON_FS_LINE    = 1,
  parameter int MON_LS_FIRST   = 18,
  parameter int MON_LS_LAST    = 314,
  parameter int STORE_LINES    = 298,
  parameter int EDGE_LINES     = 16,
  parameter int ACTIVE_LINES   = 1296,
  parameter int TOP_LINES      = 12,
  parameter int SUB_SPAN       = 1290,
  parameter int KEEP           = 2,
  parameter int GROUP          = 10,
  parameter int FS_DIV         = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strb,
  input  frameMode_t     activeMode,
  input  logic           pixEn,
  output logic [LCW-1:0] lineCount,
  output logic           atLast,
  output logic           atFsPrev,
  output logic           chargeReset,
  output logic           frameShiftEn,
  output logic           xferStrobe,
  output logic           keepStrobe,
  output logic           lineShiftEn,
  output logic           lineValid,
  output logic           frameValid
);

  localparam int XFERS         = EDGE_LINES + ACTIVE_LINES + TOP_LINES;
  localparam int XW            = $clog2(XFERS + 1);
  localparam int DW            = $clog2(FS_DIV);
  localparam int GW            = $clog2(GROUP);
  localparam int STILL_ACT_LO  = STILL_LS_FIRST + STORE_LINES + EDGE_LINES;
  localparam int STILL_ACT_HI  = STILL_ACT_LO + ACTIVE_LINES - 1;
  localparam int MON_ACT_LO    = MON_LS_FIRST + EDGE_LINES;
  localparam int MON_ACT_HI    = MON_ACT_LO + (SUB_SPAN / GROUP) * KEEP - 1;

  localparam logic [LCW-1:0] STILL_LAST_C = LCW'(STILL_LINES - 1);
  localparam logic [LCW-1:0] MON_LAST_C   = LCW'(MON_LINES - 1);
  localparam logic [LCW-1:0] STILL_CR_C   = LCW'(STILL_CR);
  localparam logic [LCW-1:0] MON_CR_C     = LCW'(MON_CR);
  localparam logic [LCW-1:0] S_LS_LO_C    = LCW'(STILL_LS_FIRST);
  localparam logic [LCW-1:0] S_LS_HI_C    = LCW'(STILL_LS_LAST);
  localparam logic [LCW-1:0] M_LS_LO_C    = LCW'(MON_LS_FIRST);
  localparam logic [LCW-1:0] M_LS_HI_C    = LCW'(MON_LS_LAST);
  localparam logic [LCW-1:0] S_ACT_LO_C   = LCW'(STILL_ACT_LO);
  localparam logic [LCW-1:0] S_ACT_HI_C   = LCW'(STILL_ACT_HI);
  localparam logic [LCW-1:0] M_ACT_LO_C   = LCW'(MON_ACT_LO);
  localparam logic [LCW-1:0] M_ACT_HI_C   = LCW'(MON_ACT_HI);
  localparam logic [LCW-1:0] FS_PREV_C    = LCW'(MON_FS_LINE - 1);

  localparam logic [XW-1:0]  EDGE_C       = XW'(EDGE_LINES);
  localparam logic [XW-1:0]  SPAN_END_C   = XW'(EDGE_LINES + SUB_SPAN);
  localparam logic [XW-1:0]  XFER_LAST_C  = XW'(XFERS - 1);
  localparam logic [DW-1:0]  DIV_LAST_C   = DW'(FS_DIV - 1);
  localparam logic [GW-1:0]  GRP_LAST_C   = GW'(GROUP - 1);
  localparam logic [GW-1:0]  KEEP_C       = GW'(KEEP);

  logic           isMon;
  logic [LCW-1:0] lastLine;
  logic           fsActive;
  logic [XW-1:0]  xferIdx;
  logic [DW-1:0]  divCnt;
  logic [GW-1:0]  grpCnt;
  logic           stepDone;
  logic           keepNow;

  assign isMon    = (activeMode == MODE_MONITOR);
  assign lastLine = isMon ? MON_LAST_C : STILL_LAST_C;
  assign atLast   = (lineCount == lastLine);
  assign atFsPrev = (lineCount == FS_PREV_C);

  // line counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCount <= '0;
    end else if (strb.lineAdv) begin
      lineCount <= atLast ? '0 : lineCount + 1'b1;
    end
  end

  // fast transfer: divider, step index, subsampling phase
  assign stepDone = fsActive && pixEn && (divCnt == DIV_LAST_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsActive <= 1'b0;
      xferIdx  <= '0;
      divCnt   <= '0;
      grpCnt   <= '0;
    end else if (strb.fsStart) begin
      fsActive <= 1'b1;
      xferIdx  <= '0;
      divCnt   <= '0;
      grpCnt   <= '0;
    end else if (strb.frameWrap) begin
      fsActive <= 1'b0;
    end else if (fsActive && pixEn) begin
      if (divCnt == DIV_LAST_C) begin
        divCnt <= '0;
        if (xferIdx >= EDGE_C) begin
          grpCnt <= (grpCnt == GRP_LAST_C) ? '0 : grpCnt + 1'b1;
        end
        if (xferIdx == XFER_LAST_C) begin
          fsActive <= 1'b0;
        end else begin
          xferIdx <= xferIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign keepNow = (xferIdx < EDGE_C) ||
                   ((xferIdx < SPAN_END_C) && (grpCnt < KEEP_C));

  // decodes
  always_comb begin
    frameValid   = strb.running;
    frameShiftEn = fsActive;
    xferStrobe   = stepDone;
    keepStrobe   = stepDone && keepNow;
    chargeReset  = strb.running && (lineCount == (isMon ? MON_CR_C : STILL_CR_C));
    if (isMon) begin
      lineShiftEn = strb.running && (lineCount >= M_LS_LO_C) && (lineCount <= M_LS_HI_C);
      lineValid   = strb.running && (lineCount >= M_ACT_LO_C) && (lineCount <= M_ACT_HI_C);
    end else begin
      lineShiftEn = strb.running && (lineCount >= S_LS_LO_C) && (lineCount <= S_LS_HI_C);
      lineValid   = strb.running && (lineCount >= S_ACT_LO_C) && (lineCount <= S_ACT_HI_C);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> (lineCount == '0 && !chargeReset && !frameShiftEn && !lineShiftEn)); // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lineAdv |=> $stable(lineCount)); // R3

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lineCount <= lastLine); // R4

  AST_VALID_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> lineShiftEn); // R7

  AST_FS_MONITOR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    frameShiftEn |-> isMon); // R8

  AST_KEEP_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    keepStrobe |-> xferStrobe); // R9

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_frame_seq_pkg::*;
#(
  parameter int STILL_LINES    = 2035,
  parameter int MON_LINES      = 315,
  parameter int STILL_CR       = 1628,
  parameter int MON_CR         = 113,
  parameter int STILL_LS_FIRST = 2,
  parameter int STILL_LS_LAST  = 1626,
  parameter int MON_FS_LINE    = 1,
  parameter int MON_LS_FIRST   = 18,
  parameter int MON_LS_LAST    = 314,
  parameter int STORE_LINES    = 298,
  parameter int EDGE_LINES     = 16,
  parameter int ACTIVE_LINES   = 1296,
  parameter int TOP_LINES      = 12,
  parameter int SUB_SPAN       = 1290,
  parameter int KEEP           = 2,
  parameter int GROUP          = 10,
  parameter int FS_DIV         = 16,
  localparam int MAX_LINES     = (STILL_LINES > MON_LINES) ? STILL_LINES : MON_LINES,
  localparam int LCW           = $clog2(MAX_LINES)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pixEn,
  input  logic           lineEnd,
  input  logic           modeMonitor,
  input  logic           startReq,
  output logic [LCW-1:0] lineCount,
  output logic           chargeReset,
  output logic           frameShiftEn,
  output logic           xferStrobe,
  output logic           keepStrobe,
  output logic           lineShiftEn,
  output logic           frameValid,
  output logic           lineValid
);

  seqStrobe_t strb;
  frameMode_t activeMode;
  logic       atLast;
  logic       atFsPrev;

  ccd_frame_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .pixEn       (pixEn),
    .lineEnd     (lineEnd),
    .startReq    (startReq),
    .modeMonitor (modeMonitor),
    .atLast      (atLast),
    .atFsPrev    (atFsPrev),
    .strb        (strb),
    .activeMode  (activeMode)
  );

  ccd_frame_seq_dpath #(
    .LCW            (LCW),
    .STILL_LINES    (STILL_LINES),
    .MON_LINES      (MON_LINES),
    .STILL_CR       (STILL_CR),
    .MON_CR         (MON_CR),
    .STILL_LS_FIRST (STILL_LS_FIRST),
    .STILL_LS_LAST  (STILL_LS_LAST),
    .MON_FS_LINE    (MON_FS_LINE),
    .MON_LS_FIRST   (MON_LS_FIRST),
    .MON_LS_LAST    (MON_LS_LAST),
    .STORE_LINES    (STORE_LINES),
    .EDGE_LINES     (EDGE_LINES),
    .ACTIVE_LINES   (ACTIVE_LINES),
    .TOP_LINES      (TOP_LINES),
    .SUB_SPAN       (SUB_SPAN),
    .KEEP           (KEEP),
    .GROUP          (GROUP),
    .FS_DIV         (FS_DIV)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .activeMode   (activeMode),
    .pixEn        (pixEn),
    .lineCount    (lineCount),
    .atLast       (atLast),
    .atFsPrev     (atFsPrev),
    .chargeReset  (chargeReset),
    .frameShiftEn (frameShiftEn),
    .xferStrobe   (xferStrobe),
    .keepStrobe   (keepStrobe),
    .lineShiftEn  (lineShiftEn),
    .lineValid    (lineValid),
    .frameValid   (frameValid)
  );

endmodule

// File: tb/ccd_frame_seq_tb_top.sv
module ccd_frame_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  // compact geometry
  localparam int STILL_LINES = 60;
  localparam int MON_LINES   = 40;
  localparam int STILL_CR    = 50;
  localparam int MON_CR      = 30;
  localparam int S_LS_LO     = 2;
  localparam int S_LS_HI     = 48;
  localparam int FS_LINE     = 1;
  localparam int M_LS_LO     = 10;
  localparam int M_LS_HI     = 39;
  localparam int STORE       = 6;
  localparam int EDGE        = 4;
  localparam int ACTIVE      = 24;
  localparam int TOP         = 3;
  localparam int SPAN        = 20;
  localparam int KEEPN       = 2;
  localparam int GRP         = 10;
  localparam int DIV         = 4;
  localparam int NXFER       = EDGE + ACTIVE + TOP;
  localparam int NKEPT       = EDGE + (SPAN / GRP) * KEEPN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixEn = 1'b0, lineEnd = 1'b0, modeMonitor = 1'b0, startReq = 1'b0;
  logic [5:0] lineCount;
  logic chargeReset, frameShiftEn, xferStrobe, keepStrobe, lineShiftEn, frameValid, lineValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_frame_seq #(
    .STILL_LINES(STILL_LINES), .MON_LINES(MON_LINES), .STILL_CR(STILL_CR), .MON_CR(MON_CR),
    .STILL_LS_FIRST(S_LS_LO), .STILL_LS_LAST(S_LS_HI), .MON_FS_LINE(FS_LINE),
    .MON_LS_FIRST(M_LS_LO), .MON_LS_LAST(M_LS_HI), .STORE_LINES(STORE), .EDGE_LINES(EDGE),
    .ACTIVE_LINES(ACTIVE), .TOP_LINES(TOP), .SUB_SPAN(SPAN), .KEEP(KEEPN), .GROUP(GRP),
    .FS_DIV(DIV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineEnd(lineEnd), .modeMonitor(modeMonitor),
    .startReq(startReq), .lineCount(lineCount), .chargeReset(chargeReset),
    .frameShiftEn(frameShiftEn), .xferStrobe(xferStrobe), .keepStrobe(keepStrobe),
    .lineShiftEn(lineShiftEn), .frameValid(frameValid), .lineValid(lineValid)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  int mRun = 0, mMon = 0, mLine = 0, mFs = 0, mXfer = 0, mDiv = 0;
  int frameMon = 0;         // mode the current DUT frame was run in
  int prevLine = 0, prevFs = 0, cntX = 0, cntK = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      if (nFails <= 25)
        $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int keepOf(input int k);
    if (k < EDGE) return 1;
    if (k - EDGE < SPAN && ((k - EDGE) % GRP) < KEEPN) return 1;
    return 0;
  endfunction

  function automatic int inRange(input int v, input int lo, input int hi);
    return (v >= lo && v <= hi) ? 1 : 0;
  endfunction

  // advance the reference on a clock edge using the inputs held there
  task automatic modelStep();
    int lastL;
    if (mRun == 0) begin
      if (startReq) begin mRun = 1; mMon = modeMonitor; mLine = 0; end
      return;
    end
    if (mFs != 0 && pixEn) begin
      if (mDiv == DIV - 1) begin
        mDiv = 0;
        if (mXfer == NXFER - 1) mFs = 0; else mXfer++;
      end else mDiv++;
    end
    if (pixEn && lineEnd) begin
      lastL = mMon ? MON_LINES - 1 : STILL_LINES - 1;
      if (mLine == lastL) begin
        mLine = 0; mMon = modeMonitor; mFs = 0;
      end else begin
        mLine++;
        if (mMon != 0 && mLine == FS_LINE) begin mFs = 1; mXfer = 0; mDiv = 0; end
      end
    end
  endtask

  task automatic compareAll();
    int eCr, eLs, eLv, eX, eK, actLo, actHi;
    string rl;
    eCr = (mRun != 0 && mLine == (mMon ? MON_CR : STILL_CR)) ? 1 : 0;
    if (mMon != 0) begin
      actLo = M_LS_LO + EDGE; actHi = actLo + (SPAN / GRP) * KEEPN - 1;
      eLs = mRun & inRange(mLine, M_LS_LO, M_LS_HI);
      rl = "R10";
    end else begin
      actLo = S_LS_LO + STORE + EDGE; actHi = actLo + ACTIVE - 1;
      eLs = mRun & inRange(mLine, S_LS_LO, S_LS_HI);
      rl = "R7";
    end
    eLv = mRun & inRange(mLine, actLo, actHi);
    eX  = (mFs != 0 && pixEn && mDiv == DIV - 1) ? 1 : 0;
    eK  = eX & keepOf(mXfer);
    check(frameValid == mRun, "R2", "frameValid", frameValid, mRun);
    check(int'(lineCount) == mLine, "R3", "lineCount", lineCount, mLine);
    check(chargeReset == eCr, "R6", "chargeReset", chargeReset, eCr);
    check(lineShiftEn == eLs, rl, "lineShiftEn", lineShiftEn, eLs);
    check(lineValid == eLv, rl, "lineValid", lineValid, eLv);
    check(frameShiftEn == mFs, "R8", "frameShiftEn", frameShiftEn, mFs);
    check(xferStrobe == eX, "R8", "xferStrobe", xferStrobe, eX);
    check(keepStrobe == eK, "R9", "keepStrobe", keepStrobe, eK);

    // per-frame length: R4 with the mode latched at the previous wrap (R5)
    if (frameValid && lineCount == 0 && prevLine != 0) begin
      check(prevLine + 1 == (frameMon ? MON_LINES : STILL_LINES), "R4", "frame length (R5 mode hold)",
            prevLine + 1, frameMon ? MON_LINES : STILL_LINES);
      frameMon = mMon;
    end
    prevLine = int'(lineCount);

    // per-transfer totals
    if (frameShiftEn && !prevFs) begin cntX = 0; cntK = 0; end
    if (xferStrobe) cntX++;
    if (keepStrobe) cntK++;
    if (!frameShiftEn && prevFs) begin
      check(cntX == NXFER, "R8", "transfer count", cntX, NXFER);
      check(cntK == NKEPT, "R9", "kept count", cntK, NKEPT);
    end
    prevFs = frameShiftEn;
  endtask

  task automatic run(input int n, input int lp, input bit gappy, input bit mmA,
                     input bit mmB, input int sw, input int startAt);
    for (int i = 0; i < n; i++) begin
      pixEn       = gappy ? (i % 4 != 3) : 1'b1;
      lineEnd     = (i % lp == lp - 1);
      modeMonitor = (i < sw) ? mmA : mmB;
      startReq    = (i == startAt);
      @(posedge clk);
      modelStep();
      if (startReq && mLine == 0 && mRun != 0 && frameValid == 1'b0) frameMon = mMon;
      @(negedge clk);
      if (i == startAt && prevLine == 0 && !prevFs) frameMon = mMon;
      compareAll();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(lineCount == 0, "R1", "lineCount after reset", lineCount, 0);
    check(frameValid == 0, "R1", "frameValid after reset", frameValid, 0);
    check(chargeReset == 0 && lineShiftEn == 0 && lineValid == 0, "R1", "line flags after reset",
          chargeReset + lineShiftEn + lineValid, 0);
    check(frameShiftEn == 0 && xferStrobe == 0 && keepStrobe == 0, "R1", "transfer flags after reset",
          frameShiftEn + xferStrobe + keepStrobe, 0);
    // R1: line strobes without a start do nothing
    run(60, 20, 1'b0, 1'b1, 1'b1, 0, -1);
    check(lineCount == 0 && frameValid == 0, "R1", "idle held without start", lineCount, 0);
    // R2 start in still; R5 request monitor mid second frame
    run(2000, 20, 1'b0, 1'b0, 1'b1, 1700, 3);
    // monitor frames; R2 start while running ignored
    run(2500, 20, 1'b0, 1'b1, 1'b1, 0, 100);
    // R3 gapped enable, monitor then switch back to still
    run(2500, 22, 1'b1, 1'b1, 1'b0, 1500, 50);
    run(2000, 20, 1'b1, 1'b0, 1'b0, 0, -1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule